// File: doc/BRIEF.md
# MSI-to-SPI Doorbell Register Frame

This block is a 4 KB register window that converts message-signalled interrupt writes into interrupt pulses. A device or a bridge writes an interrupt number to a doorbell register. The frame checks that number against a fixed window of shared peripheral interrupt lines. If the number falls inside the window, the frame raises the matching output for one clock cycle. The window's first line and its line count are elaboration parameters, `BASE_SPI` and `NUM_SPI`. Interrupt numbers sit 32 above the base, so the first accepted number is `BASE_SPI + 32`.

Software finds the window through a packed type register. An identification register and a block of identification words, which all read as zero, complete the read side. The bus is simple. It carries a 12-bit byte offset, an access size given as a byte count, read and write strobes, write data, and registered read data. The frame never raises a bus error. Accesses it cannot use are dropped silently.

Elaboration checks keep `NUM_SPI` between 1 and 128. They also keep `BASE_SPI + 32 + NUM_SPI` at or below 1020.

Top module: `msi_doorbell_frame`

## Requirements
- R1: While `rst_n` is low at a rising edge, `spi_pulse` and `bus_rdata` are cleared to zero. This holds even if a read or doorbell strobe is asserted in that cycle.
- R2: A 4-byte read of offset 0x008 returns `BASE_SPI + 32` in bits [31:16] and `NUM_SPI` in bits [15:0].
- R3: A 4-byte read of offset 0xFCC returns 0x0510_0000. This is the value 0x51 in bits [27:20], with all other bits zero.
- R4: A 4-byte read of any offset in 0xFD0 to 0xFFC returns zero. So does a read of any offset other than 0x008 and 0xFCC.
- R5: Read data appears in the cycle after the cycle in which `bus_rd` is sampled high. In every cycle that does not follow a read strobe, `bus_rdata` is zero.
- R6: A read whose `bus_size` (byte count) is not 4 returns zero, at any offset.
- R7: A write to offset 0x040 with `bus_size` of 2 or 4 takes `bus_wdata[9:0]` as an interrupt number N and ignores bits [31:10]. If N lies in the accepted range, it drives `spi_pulse[N - (BASE_SPI + 32)]` high for exactly the one cycle after the strobe. No other line is driven.
- R8: A doorbell number below `BASE_SPI + 32`, or at or above `BASE_SPI + 32 + NUM_SPI`, produces no pulse.
- R9: A write whose `bus_size` is neither 2 nor 4 produces no pulse, even when it targets the doorbell with a valid number.
- R10: A write to any offset other than 0x040 produces no pulse.
- R11: Doorbell writes on consecutive cycles each produce their own pulse, one cycle after their own strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 12 | Byte offset within the 4 KB window |
| bus_size | input | 3 | Access size as a byte count (1, 2 or 4) |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data, little-endian |
| bus_rdata | output | 32 | Registered read data |
| spi_pulse | output | NUM_SPI | One-cycle interrupt pulses, bit i for interrupt BASE_SPI + 32 + i |

## Verification
The bench uses a window that does not start at zero. It aims doorbell numbers at the first line, the last line, and the numbers one below and one past the range. A range test that is off by one, or that forgets the 32 offset, would pulse a neighbouring line or skip an end line.

Doorbell writes are also sent with illegal sizes and to nearby offsets, including a halfword at 0x042. A decoder that ignored the size or the low address bits would fire a line there. The upper data bits are filled with noise, which exposes a comparator that looks past bit 9.

Back-to-back doorbells are checked for a pulse in each of the two cycles. Reads are checked both in the data cycle and in the cycle after it, which catches data that is held too long. Sub-word reads of the type register must return zero.

// File: rtl/msi_doorbell_pkg.sv
// Shared constants and types for the doorbell register frame.
// Assumes a 12-bit byte offset and a 32-bit data bus.
package msi_doorbell_pkg;
    localparam int unsigned ID_OFFSET   = 32;   // interrupt numbers start 32 above line base
    localparam int unsigned ID_BITS     = 10;   // width of the doorbell number field
    localparam int unsigned MAX_LINES   = 128;
    localparam int unsigned ID_CEILING  = 1020;
    localparam int unsigned OFS_W       = 12;
    localparam int unsigned DATA_W      = 32;

    localparam logic [OFS_W-1:0] OFS_TYPE     = 12'h008;
    localparam logic [OFS_W-1:0] OFS_DOORBELL = 12'h040;
    localparam logic [OFS_W-1:0] OFS_IDENT    = 12'hFCC;
    localparam logic [OFS_W-1:0] OFS_IDBLK_LO = 12'hFD0;
    localparam logic [OFS_W-1:0] OFS_IDBLK_HI = 12'hFFC;

    localparam logic [DATA_W-1:0] IDENT_VALUE = 32'h0510_0000;

    typedef enum logic [1:0] {
        SEL_NONE  = 2'd0,
        SEL_TYPE  = 2'd1,
        SEL_IDENT = 2'd2,
        SEL_ZERO  = 2'd3
    } rd_sel_e;
endpackage

// File: rtl/mdb_reg_decode.sv
// Address and size decoder for the doorbell frame.
// Purely combinational. A read is accepted only at 4 bytes; a doorbell
// write only at 2 or 4 bytes and only at the exact doorbell offset.
module mdb_reg_decode
    import msi_doorbell_pkg::*;
(
    input  logic [OFS_W-1:0] addr,
    input  logic [2:0]       size,
    input  logic             rd,
    input  logic             wr,
    output rd_sel_e          rd_sel,
    output logic             db_wr
);
    logic rd_ok;
    logic wr_ok;

    // size qualification for each direction
    always_comb begin
        rd_ok = rd && (size == 3'd4);
        wr_ok = wr && ((size == 3'd2) || (size == 3'd4));
    end

    // pick the read source from the offset
    always_comb begin
        rd_sel = SEL_NONE;
        if (rd_ok) begin
            if (addr == OFS_TYPE)
                rd_sel = SEL_TYPE;
            else if (addr == OFS_IDENT)
                rd_sel = SEL_IDENT;
            else if (addr >= OFS_IDBLK_LO && addr <= OFS_IDBLK_HI)
                rd_sel = SEL_ZERO;
            else
                rd_sel = SEL_NONE;
        end
    end

    // doorbell strobe when offset and size both qualify
    always_comb begin
        db_wr = wr_ok && (addr == OFS_DOORBELL);
    end
endmodule

// File: rtl/mdb_read_mux.sv
// Registered read-data path for the doorbell frame.
// Assumes the decoder already filtered size; any unselected cycle yields zero.
module mdb_read_mux
    import msi_doorbell_pkg::*;
#(
    parameter int unsigned FIRST_ID  = 32,
    parameter int unsigned LINE_CNT  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  rd_sel_e           rd_sel,
    output logic [DATA_W-1:0] rdata
);
    localparam logic [DATA_W-1:0] TYPE_VALUE = {16'(FIRST_ID), 16'(LINE_CNT)};

    // capture the selected register value, zero otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else begin
            case (rd_sel)
                SEL_TYPE:  rdata <= TYPE_VALUE;
                SEL_IDENT: rdata <= IDENT_VALUE;
                default:   rdata <= '0;
            endcase
        end
    end

    // R3
    ident_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rd_sel) == SEL_IDENT) |-> (rdata == 32'h0510_0000));
endmodule

// File: rtl/mdb_pulse_gen.sv
// Range check and pulse generation for doorbell writes.
// Assumes db_wr is already qualified by offset and size. One line per
// accepted write, registered, high for one cycle.
module mdb_pulse_gen
    import msi_doorbell_pkg::*;
#(
    parameter int unsigned FIRST_ID = 32,
    parameter int unsigned LINE_CNT = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                db_wr,
    input  logic [ID_BITS-1:0]  db_id,
    output logic [LINE_CNT-1:0] pulse
);
    localparam int unsigned  CALC_W  = ID_BITS + 1;
    localparam logic [CALC_W-1:0] LO_ID  = CALC_W'(FIRST_ID);
    localparam logic [CALC_W-1:0] END_ID = CALC_W'(FIRST_ID + LINE_CNT);

    logic [CALC_W-1:0] id_ext;
    logic [CALC_W-1:0] rel_idx;
    logic              hit;

    // relative line index and range test
    always_comb begin
        id_ext  = {1'b0, db_id};
        rel_idx = id_ext - LO_ID;
        hit     = db_wr && (id_ext >= LO_ID) && (id_ext < END_ID);
    end

    for (genvar i = 0; i < LINE_CNT; i++) begin : g_line
        localparam logic [CALC_W-1:0] LINE_IDX = CALC_W'(i);
        // drive this line for one cycle when the write selects it
        always_ff @(posedge clk) begin
            if (!rst_n)
                pulse[i] <= 1'b0;
            else
                pulse[i] <= hit && (rel_idx == LINE_IDX);
        end
    end

    // R7
    single_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pulse));
    // R11
    pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse != '0) |-> ($past(db_wr) && $past(rst_n)));
endmodule

// File: rtl/msi_doorbell_frame.sv
// Doorbell register frame: turns interrupt-number writes into one-cycle
// pulses on a parameterised bank of lines, and exposes type and ID reads.
// Assumes BASE_SPI and NUM_SPI respect the limits checked below.
module msi_doorbell_frame
    import msi_doorbell_pkg::*;
#(
    parameter int unsigned BASE_SPI = 0,
    parameter int unsigned NUM_SPI  = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [11:0]        bus_addr,
    input  logic [2:0]         bus_size,
    input  logic               bus_rd,
    input  logic               bus_wr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic [NUM_SPI-1:0] spi_pulse
);
    localparam int unsigned FIRST_ID = BASE_SPI + ID_OFFSET;

    if (NUM_SPI < 1 || NUM_SPI > MAX_LINES) begin : g_bad_count
        $error("msi_doorbell_frame: NUM_SPI out of range");
    end
    if (FIRST_ID + NUM_SPI > ID_CEILING) begin : g_bad_span
        $error("msi_doorbell_frame: interrupt range passes 1020");
    end

    rd_sel_e rd_sel;
    logic    db_wr;
    logic    unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[31:ID_BITS];

    mdb_reg_decode u_decode (
        .addr   (bus_addr),
        .size   (bus_size),
        .rd     (bus_rd),
        .wr     (bus_wr),
        .rd_sel (rd_sel),
        .db_wr  (db_wr)
    );

    mdb_read_mux #(
        .FIRST_ID (FIRST_ID),
        .LINE_CNT (NUM_SPI)
    ) u_rmux (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_sel (rd_sel),
        .rdata  (bus_rdata)
    );

    mdb_pulse_gen #(
        .FIRST_ID (FIRST_ID),
        .LINE_CNT (NUM_SPI)
    ) u_pulse (
        .clk   (clk),
        .rst_n (rst_n),
        .db_wr (db_wr),
        .db_id (bus_wdata[ID_BITS-1:0]),
        .pulse (spi_pulse)
    );

    // R2
    type_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(bus_rd) && $past(bus_size) == 3'd4 && $past(bus_addr) == 12'h008)
        |-> (bus_rdata == {16'(FIRST_ID), 16'(NUM_SPI)}));
    // R5
    idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_rd) |-> (bus_rdata == '0));
    // R6
    narrow_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(bus_rd) && $past(bus_size) != 3'd4) |-> (bus_rdata == '0));
    // R9
    bad_size_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(bus_wr) && $past(bus_size) != 3'd2 && $past(bus_size) != 3'd4)
        |-> (spi_pulse == '0));
    // R10
    other_ofs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(bus_addr) != 12'h040) |-> (spi_pulse == '0));
endmodule

// File: tb/sim_msi_doorbell_frame.sv
module sim_msi_doorbell_frame;
    localparam int BASE  = 10;
    localparam int NUM   = 40;
    localparam int FIRST = BASE + 32;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [11:0]     bus_addr;
    logic [2:0]      bus_size;
    logic            bus_rd;
    logic            bus_wr;
    logic [31:0]     bus_wdata;
    logic [31:0]     bus_rdata;
    logic [NUM-1:0]  spi_pulse;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    msi_doorbell_frame #(.BASE_SPI(BASE), .NUM_SPI(NUM)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .spi_pulse(spi_pulse)
    );

    function automatic logic [31:0] exp_read(logic [11:0] a, logic [2:0] s);
        if (s != 3'd4)     return 32'h0;
        if (a == 12'h008)  return {16'(FIRST), 16'(NUM)};
        if (a == 12'hFCC)  return 32'h0510_0000;
        return 32'h0;
    endfunction

    function automatic logic [NUM-1:0] exp_pulse(logic [11:0] a, logic [2:0] s, logic [31:0] d);
        logic [NUM-1:0] v = '0;
        int id;
        if (a != 12'h040 || (s != 3'd2 && s != 3'd4)) return v;
        id = int'(d[9:0]) - FIRST;
        if (id >= 0 && id < NUM) v[id] = 1'b1;
        return v;
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_wr(string tag, logic [11:0] a, logic [2:0] s, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_size = s; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        chk(tag, 64'(spi_pulse), 64'(exp_pulse(a, s, d)));
        @(negedge clk);
        chk({tag, " R7 one-cycle"}, 64'(spi_pulse), 64'h0);
    endtask

    task automatic do_rd(string tag, logic [11:0] a, logic [2:0] s);
        @(negedge clk);
        bus_addr = a; bus_size = s; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        chk(tag, 64'(bus_rdata), 64'(exp_read(a, s)));
        @(negedge clk);
        chk({tag, " R5 cleared"}, 64'(bus_rdata), 64'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [11:0] a;
        logic [2:0]  s;
        logic [31:0] d;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; bus_addr = 12'h040; bus_size = 3'd4;
        bus_wdata = 32'(FIRST); bus_wr = 1'b1; bus_rd = 1'b1;
        repeat (3) @(negedge clk);
        // R1: strobes during reset are dropped
        chk("R1 pulse in reset", 64'(spi_pulse), 64'h0);
        chk("R1 rdata in reset", 64'(bus_rdata), 64'h0);
        bus_wr = 1'b0; bus_rd = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 pulse after reset", 64'(spi_pulse), 64'h0);

        do_rd("R2 type read", 12'h008, 3'd4);
        do_rd("R3 ident read", 12'hFCC, 3'd4);
        do_rd("R4 id block low", 12'hFD0, 3'd4);
        do_rd("R4 id block high", 12'hFFC, 3'd4);
        do_rd("R4 doorbell read", 12'h040, 3'd4);
        do_rd("R6 type read size 2", 12'h008, 3'd2);
        do_rd("R6 ident read size 1", 12'hFCC, 3'd1);

        do_wr("R7 first line", 12'h040, 3'd4, 32'hFFFF_FC00 | 32'(FIRST));
        do_wr("R7 last line", 12'h040, 3'd2, 32'(FIRST + NUM - 1));
        do_wr("R7 mid line hi noise", 12'h040, 3'd4, 32'hABCD_E400 | 32'(FIRST + 7));
        do_wr("R8 below range", 12'h040, 3'd4, 32'(FIRST - 1));
        do_wr("R8 past range", 12'h040, 3'd4, 32'(FIRST + NUM));
        do_wr("R8 base without offset", 12'h040, 3'd4, 32'(BASE));
        do_wr("R9 size 1", 12'h040, 3'd1, 32'(FIRST + 3));
        do_wr("R9 size 3", 12'h040, 3'd3, 32'(FIRST + 3));
        do_wr("R10 offset 0x042", 12'h042, 3'd2, 32'(FIRST + 3));
        do_wr("R10 offset 0x008", 12'h008, 3'd4, 32'(FIRST + 3));

        // R11: back-to-back doorbells
        @(negedge clk);
        bus_addr = 12'h040; bus_size = 3'd4; bus_wdata = 32'(FIRST + 2); bus_wr = 1'b1;
        @(negedge clk);
        chk("R11 first of pair", 64'(spi_pulse), 64'(exp_pulse(12'h040, 3'd4, 32'(FIRST + 2))));
        bus_wdata = 32'(FIRST + 5);
        @(negedge clk);
        bus_wr = 1'b0;
        chk("R11 second of pair", 64'(spi_pulse), 64'(exp_pulse(12'h040, 3'd4, 32'(FIRST + 5))));
        @(negedge clk);
        chk("R11 idle after pair", 64'(spi_pulse), 64'h0);

        for (int k = 0; k < 500; k++) begin
            case ($urandom % 6)
                0: a = 12'h008;
                1, 2: a = 12'h040;
                3: a = 12'hFCC;
                4: a = 12'hFD0 + 12'(4 * ($urandom % 12));
                default: a = 12'($urandom);
            endcase
            case ($urandom % 4)
                0: s = 3'd2;
                1: s = 3'($urandom);
                default: s = 3'd4;
            endcase
            d = $urandom;
            if ($urandom % 4 != 0) d[9:0] = 10'(FIRST - 3 + int'($urandom % (NUM + 6)));
            if ($urandom % 2 == 0) do_wr("R7 R8 R9 R10 random write", a, s, d);
            else                   do_rd("R2 R4 R6 random read", a, s);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule